// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This block is a packed integer datapath for two 32-bit operands. It can treat the operands as four byte lanes, as two halfword lanes or as one 32-bit word. It performs addition and subtraction in wrapping, saturating and halving forms, each signed or unsigned. Two halfword forms swap the halves of the second operand, so that one lane adds while the other subtracts.

The wrapping lane forms write a 4-bit greater-or-equal flag register. A byte select operation then uses that register to merge the two operands byte by byte. This is the usual way to build per-lane max, min or conditional moves. The unit also computes an unsigned sum of absolute byte differences, with an optional accumulator, and a 32-bit signed saturating add and subtract.

The result is combinational from the operands and the opcode. Only the flag register is clocked.

Top module: `simd_addsub`

## Requirements
- R1: The opcode is decoded as follows. op_i[5:4] is the class: 0 wrap, 1 saturate, 2 halve, 3 misc. op_i[3] set means unsigned. op_i[2:0] is the form, and for classes 0 to 2 it is: 0 byte add, 1 byte subtract, 2 halfword add, 3 halfword subtract, 4 add-subtract-exchange, 5 subtract-add-exchange. For class 3 the form is: 0 byte select, 1 sum of absolute differences, 2 sum of absolute differences plus acc_i, 3 word saturating add, 4 word saturating subtract. Any form not listed gives res_o = 0.
- R2: The wrap class returns each lane result modulo 2^lane width.
- R3: The saturate class clamps each lane. Signed lanes clamp to [-2^(w-1), 2^(w-1)-1] and unsigned lanes to [0, 2^w-1].
- R4: The halve class returns the exact (w+1)-bit lane result shifted right by one, rounding toward minus infinity.
- R5: In the add-subtract-exchange form, the upper half is A.hi + B.lo and the lower half is A.lo - B.hi. The subtract-add-exchange form subtracts in the upper half and adds in the lower half.
- R6: The wrap class produces one flag per lane. For signed lanes and for unsigned subtraction, the flag is set when the exact result is >= 0. For unsigned addition, it is set on carry-out. Halfword results fill flag pairs: ge[1:0] for the low half and ge[3:2] for the high half.
- R7: ge_o takes the new flags at the next rising clock edge only for class 0 with forms 0 to 5. Every other opcode leaves ge_o unchanged.
- R8: Byte select sets result byte i to A byte i when ge_o[i] is 1, and to B byte i otherwise.
- R9: The sum of absolute differences is the sum of |A_i - B_i| over the four unsigned bytes. The accumulating form adds acc_i, modulo 2^32.
- R10: The word forms compute the signed 32-bit A + B or A - B, clamped to 0x80000000..0x7FFFFFFF.
- R11: While rst_ni is low, ge_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the flag register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 6 | Opcode (class, unsigned, form) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| acc_i | input | 32 | Accumulator for the accumulating difference sum |
| res_o | output | 32 | Combinational result |
| ge_o | output | 4 | Registered greater-or-equal flags |

## Verification
The hardest case to reach from the ports is a select whose byte mask comes from flags written by an earlier operation, while intervening non-writing opcodes must leave those flags intact. The stimulus therefore chains operations. A signed byte add with a zero second operand plants a chosen flag pattern through the sign bits of A. Wrap unsigned and exchange forms then change the pattern, and a saturating opcode follows that must not change it. Each state is read both on ge_o and through a select of two known words. The lane and word corner cases use operands that sit at the saturation and borrow boundaries.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned N_BYTES  = WORD_W / BYTE_W;
  localparam int unsigned HALF_W   = WORD_W / 2;
  localparam int unsigned N_HALVES = 2;
  localparam int unsigned OP_W     = 6;

  typedef enum logic [1:0] {
    K_WRAP = 2'd0,
    K_SAT  = 2'd1,
    K_HALF = 2'd2,
    K_MISC = 2'd3
  } kind_e;

  localparam logic [2:0] F_ADD8  = 3'd0;
  localparam logic [2:0] F_SUB8  = 3'd1;
  localparam logic [2:0] F_ADD16 = 3'd2;
  localparam logic [2:0] F_SUB16 = 3'd3;
  localparam logic [2:0] F_ASX   = 3'd4;
  localparam logic [2:0] F_SAX   = 3'd5;

  localparam logic [2:0] M_SEL   = 3'd0;
  localparam logic [2:0] M_SAD   = 3'd1;
  localparam logic [2:0] M_SADA  = 3'd2;
  localparam logic [2:0] M_QADD  = 3'd3;
  localparam logic [2:0] M_QSUB  = 3'd4;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         sgn_i,
  input  kind_e        kind_i,
  output logic [W-1:0] res_o,
  output logic         ge_o
);
  localparam int unsigned XW = W + 2;
  localparam logic signed [XW-1:0] SMAX = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [XW-1:0] SMIN = {3'b111, {(W-1){1'b0}}};
  localparam logic signed [XW-1:0] UMAX = {2'b00, {W{1'b1}}};

  logic signed [XW-1:0] ax, bx, full;

  always_comb begin
    ax   = sgn_i ? {{2{a_i[W-1]}}, a_i} : {2'b00, a_i};
    bx   = sgn_i ? {{2{b_i[W-1]}}, b_i} : {2'b00, b_i};
    full = sub_i ? (ax - bx) : (ax + bx);
  end

  always_comb begin
    unique case (kind_i)
      K_SAT: begin
        if (sgn_i) begin
          if (full > SMAX)      res_o = SMAX[W-1:0];
          else if (full < SMIN) res_o = SMIN[W-1:0];
          else                  res_o = full[W-1:0];
        end else begin
          if (full < 0)         res_o = '0;
          else if (full > UMAX) res_o = '1;
          else                  res_o = full[W-1:0];
        end
      end
      K_HALF:  res_o = full[W:1];
      default: res_o = full[W-1:0];
    endcase
  end

  // unsigned add: carry-out; all other cases: exact result non-negative
  assign ge_o = (!sgn_i && !sub_i) ? full[W] : !full[XW-1];
endmodule

// File: rtl/simd_sad.sv
module simd_sad
  import simd_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic              acc_en_i,
  output logic [WORD_W-1:0] sum_o
);
  logic [BYTE_W-1:0] diff [N_BYTES];

  for (genvar i = 0; i < N_BYTES; i++) begin : g_diff
    logic [BYTE_W-1:0] ab, bb;
    assign ab = a_i[i*BYTE_W +: BYTE_W];
    assign bb = b_i[i*BYTE_W +: BYTE_W];
    assign diff[i] = (ab > bb) ? (ab - bb) : (bb - ab);
  end

  always_comb begin
    sum_o = acc_en_i ? acc_i : '0;
    for (int i = 0; i < N_BYTES; i++) begin
      sum_o = sum_o + WORD_W'(diff[i]);
    end
  end
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [WORD_W-1:0] acc_i,
  output logic [WORD_W-1:0] res_o,
  output logic [N_BYTES-1:0] ge_o
);
  kind_e      kind;
  logic       uns;
  logic [2:0] form;

  assign kind = kind_e'(op_i[5:4]);
  assign uns  = op_i[3];
  assign form = op_i[2:0];

  logic [WORD_W-1:0]  byte_res, half_res, word_res, sad_res, sel_res;
  logic [N_BYTES-1:0] byte_ge, ge_q, ge_d;
  logic [N_HALVES-1:0] half_ge;
  logic               ge_wr;

  // byte lanes
  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    simd_lane #(.W(BYTE_W)) i_lane (
      .a_i   (a_i[i*BYTE_W +: BYTE_W]),
      .b_i   (b_i[i*BYTE_W +: BYTE_W]),
      .sub_i (form == F_SUB8),
      .sgn_i (!uns),
      .kind_i(kind),
      .res_o (byte_res[i*BYTE_W +: BYTE_W]),
      .ge_o  (byte_ge[i])
    );
  end

  // halfword lanes, exchange forms take the opposite half of B
  for (genvar j = 0; j < N_HALVES; j++) begin : g_half
    logic              exch, sub;
    logic [HALF_W-1:0] bh;
    assign exch = (form == F_ASX) || (form == F_SAX);
    assign bh   = exch ? b_i[(N_HALVES-1-j)*HALF_W +: HALF_W] : b_i[j*HALF_W +: HALF_W];
    assign sub  = (form == F_SUB16) ||
                  ((form == F_ASX) && (j == 0)) ||
                  ((form == F_SAX) && (j == 1));
    simd_lane #(.W(HALF_W)) i_lane (
      .a_i   (a_i[j*HALF_W +: HALF_W]),
      .b_i   (bh),
      .sub_i (sub),
      .sgn_i (!uns),
      .kind_i(kind),
      .res_o (half_res[j*HALF_W +: HALF_W]),
      .ge_o  (half_ge[j])
    );
  end

  simd_lane #(.W(WORD_W)) i_word (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (form == M_QSUB),
    .sgn_i (1'b1),
    .kind_i(K_SAT),
    .res_o (word_res),
    .ge_o  ()
  );

  simd_sad i_sad (
    .a_i     (a_i),
    .b_i     (b_i),
    .acc_i   (acc_i),
    .acc_en_i(form == M_SADA),
    .sum_o   (sad_res)
  );

  for (genvar i = 0; i < N_BYTES; i++) begin : g_sel
    assign sel_res[i*BYTE_W +: BYTE_W] = ge_q[i] ? a_i[i*BYTE_W +: BYTE_W]
                                                 : b_i[i*BYTE_W +: BYTE_W];
  end

  always_comb begin
    res_o = '0;
    if (kind == K_MISC) begin
      unique case (form)
        M_SEL:          res_o = sel_res;
        M_SAD, M_SADA:  res_o = sad_res;
        M_QADD, M_QSUB: res_o = word_res;
        default:        res_o = '0;
      endcase
    end else begin
      unique case (form)
        F_ADD8, F_SUB8:                  res_o = byte_res;
        F_ADD16, F_SUB16, F_ASX, F_SAX:  res_o = half_res;
        default:                         res_o = '0;
      endcase
    end
  end

  always_comb begin
    ge_wr = (kind == K_WRAP) && (form <= F_SAX);
    if (form <= F_SUB8) ge_d = byte_ge;
    else                ge_d = {half_ge[1], half_ge[1], half_ge[0], half_ge[0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ge_q <= '0;
    else if (ge_wr) ge_q <= ge_d;
  end

  assign ge_o = ge_q;
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk
  import simd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OP_W-1:0]   op_i,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic [WORD_W-1:0] acc_i,
  input logic [WORD_W-1:0] res_o,
  input logic [N_BYTES-1:0] ge_o
);
  logic [WORD_W-1:0] mask;
  logic              uqadd_ok;

  always_comb begin
    uqadd_ok = 1'b1;
    for (int i = 0; i < N_BYTES; i++) begin
      mask[i*BYTE_W +: BYTE_W] = {BYTE_W{ge_o[i]}};
      if (res_o[i*BYTE_W +: BYTE_W] < a_i[i*BYTE_W +: BYTE_W]) uqadd_ok = 1'b0;
    end
  end

  p_ge_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[5:4] != 2'd0 || op_i[2:0] > 3'd5) |=> $stable(ge_o));

  p_ge_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 6'h00 && b_i == '0) |=>
      ge_o == ~{$past(a_i[31]), $past(a_i[23]), $past(a_i[15]), $past(a_i[7])});

  p_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 6'h30) |-> res_o == ((a_i & mask) | (b_i & ~mask)));

  p_uqadd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 6'h18) |-> uqadd_ok);

  p_sad_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 6'h31) |-> res_o[WORD_W-1:10] == '0);

  p_bad_form_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[2:0] > 3'd5) |-> res_o == '0);

  p_reset_r11: assert property (@(posedge clk_i) !rst_ni |-> ge_o == '0);
endmodule

bind simd_addsub simd_addsub_chk i_chk (.*);

// File: tb/test_simd_addsub.sv
module test_simd_addsub;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [5:0]  op_i;
  logic [31:0] a_i, b_i, acc_i;
  logic [31:0] res_o;
  logic [3:0]  ge_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  simd_addsub i_simd_addsub (.*);

  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] acc;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{6'h00, 32'h87858381, 32'h08060402, 32'h0, 32'h8F8B8783}, // R2 byte add
    '{6'h01, 32'h8F8B8783, 32'h08060402, 32'h0, 32'h87858381}, // R2 byte sub
    '{6'h04, 32'h80078003, 32'h00040002, 32'h0, 32'h80097FFF}, // R5 asx
    '{6'h05, 32'h80038007, 32'h00020004, 32'h0, 32'h7FFF8009}, // R5 sax
    '{6'h1C, 32'hFFF80003, 32'h00040009, 32'h0, 32'hFFFF0000}, // R3 unsigned sat asx
    '{6'h21, 32'h8F8B8783, 32'h08060402, 32'h0, 32'hC3C2C1C0}, // R4 signed halve sub8
    '{6'h11, 32'h808B8783, 32'h08060402, 32'h0, 32'h80858381}, // R3 signed sat sub8
    '{6'h18, 32'hFF050301, 32'h08060402, 32'h0, 32'hFF0B0703}, // R3 unsigned sat add8
    '{6'h19, 32'h080B0702, 32'h0F060408, 32'h0, 32'h00050300}, // R3 unsigned sat sub8
    '{6'h2A, 32'h00010002, 32'h00020004, 32'h0, 32'h00010003}, // R4 unsigned halve add16
    '{6'h22, 32'h80038001, 32'h00040002, 32'h0, 32'hC003C001}, // R4 signed halve add16
    '{6'h31, 32'h87858381, 32'h08060402, 32'h0, 32'h000001FC}, // R9 sad
    '{6'h32, 32'h87858381, 32'h08060402, 32'h00008000, 32'h000081FC}, // R9 sada
    '{6'h33, 32'h80000000, 32'h80000002, 32'h0, 32'h80000000}, // R10 qadd clamp
    '{6'h34, 32'h80000003, 32'h00000004, 32'h0, 32'h80000000}, // R10 qsub clamp
    '{6'h33, 32'h80000003, 32'h00000004, 32'h0, 32'h80000007}, // R10 qadd in range
    '{6'h0A, 32'hFFFE0002, 32'h00020004, 32'h0, 32'h00000006}, // R2 unsigned wrap add16
    '{6'h14, 32'h80078003, 32'h00040002, 32'h0, 32'h80098000}, // R3 signed sat asx
    '{6'h36, 32'h12345678, 32'h9ABCDEF0, 32'h0, 32'h00000000}, // R1 unused form
    '{6'h2D, 32'h80038007, 32'h00020004, 32'h0, 32'h3FFF4004}  // R4 unsigned halve sax
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; acc_i = '0;
  endtask

  // flag-writing op, then check flags after the edge
  task automatic ge_step(input string tag, input logic [5:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [3:0] exp);
    drive(op, a, b);
    @(negedge clk_i);
    chk(tag, {28'h0, ge_o}, {28'h0, exp});
  endtask

  task automatic sel_step(input string tag, input logic [31:0] exp);
    drive(6'h30, 32'h33221100, 32'h77665544);
    #1 chk(tag, res_o, exp);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #100000;
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; op_i = '0; a_i = '0; b_i = '0; acc_i = '0;
    repeat (2) @(negedge clk_i);
    chk("R11 reset flags", {28'h0, ge_o}, 32'h0);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      op_i = VECS[k].op; a_i = VECS[k].a; b_i = VECS[k].b; acc_i = VECS[k].acc;
      #1 chk($sformatf("table[%0d] op %h (R1..)", k, VECS[k].op), res_o, VECS[k].exp);
    end

    ge_step("R6 signed byte flags", 6'h00, 32'h80808000, 32'h0, 4'b0001);
    sel_step("R8 select ge=0001", 32'h77665500);
    chk("R7 select keeps flags", {28'h0, ge_o}, 32'h1);
    ge_step("R6 signed byte flags b", 6'h00, 32'h80800080, 32'h0, 4'b0010);
    sel_step("R8 select ge=0010", 32'h77661144);
    ge_step("R6 unsigned add carry", 6'h08, 32'hFF010080, 32'h01010080, 4'b1001);
    ge_step("R6 exchange halfword pairs", 6'h04, 32'h00050001, 32'h00020003, 4'b1100);
    ge_step("R6 unsigned sub borrow", 6'h0B, 32'h00010004, 32'h00020002, 4'b0011);
    ge_step("R7 saturate keeps flags", 6'h10, 32'h7F7F7F7F, 32'h01010101, 4'b0011);
    ge_step("R7 halve keeps flags", 6'h28, 32'hFFFFFFFF, 32'h01010101, 4'b0011);
    sel_step("R8 select ge=0011", 32'h77661100);

    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 chk("R11 async reset clears flags", {28'h0, ge_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    sel_step("R8 select after reset", 32'h77665544);

    finish_run();
  end
endmodule